// File: doc/BRIEF.md
# Register-Programmed Memory Copy Engine

This block copies a region of memory to another region without CPU involvement. Software programs it through a 32-bit AXI4-Lite register slave: it sets a control word, a source address, a destination address and then a byte count. Writing the byte count is what launches the copy. The engine then reads the source through the read half of an AXI4 master with a 128-bit data path and writes the same beats, in the same order, to the destination through the write half of that master. A first-in first-out store decouples the two halves.

Each copy is split into bursts no longer than a programmable maximum of 1 to 64 beats. Each burst moves 16 bytes per beat. Two keyhole options, one for each direction, pin the source address or the destination address for every burst. This lets a single peripheral register be drained or filled. Software polls a status word for an idle flag and a sticky done flag.

Top module: `mcopy_engine`

## Requirements
- R1: After reset the status word (offset 0x04) reads 0x2 (idle bit 1 set, done bit 0 clear) and the control word (offset 0x00) reads 0x3F00. No AR, AW or W valid is asserted.
- R2: The source address (0x18), the destination address (0x20) and the byte count (0x28) read back exactly as written while the engine is idle. In the control word (0x00), bit 4 is keyhole read, bit 5 is keyhole write, and bits 13:8 hold the maximum burst length minus one. All other control bits read as zero.
- R3: Writing a byte count N with N/16 nonzero, while idle, starts a copy of N/16 beats of 128 bits each. Bits 3:0 of N are not used. Every beat read from the source is written to the destination exactly once and in the same order.
- R4: Bursts carry min(remaining, max) beats, where max is control bits 13:8 plus one, and AxLEN is that count minus one. A 512-byte copy with max at least 32 goes out as one read burst and one write burst, each with AxLEN = 0x1F.
- R5: With keyhole off, a burst uses INCR (AxBURST = 01) and AxSIZE = 4. Each burst starts 16 bytes times the beats already moved past the programmed address.
- R6: With control bit 4 set, every read burst uses FIXED (ARBURST = 00) and carries the programmed source address.
- R7: With control bit 5 set, every write burst uses FIXED (AWBURST = 00) and carries the programmed destination address.
- R8: When ARREADY, RVALID, AWREADY, WREADY or BVALID stall at any point, including mid-burst, no beat is lost, duplicated or reordered. AR, AW and W stay stable until accepted.
- R9: While a copy runs, writes to offsets 0x00, 0x18, 0x20 and 0x28 are ignored. They neither start a second copy nor change the read-back values.
- R10: Writing a byte count whose N/16 is zero issues no AR or AW and sets done at once, with idle still set.
- R11: Done is set by the final write response and cleared when a new copy starts. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. Idle (bit 1) reads 0 while a copy runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 8 | Register write address |
| s_awvalid | input | 1 | Register write address valid |
| s_awready | output | 1 | Register write address ready |
| s_wdata | input | 32 | Register write data |
| s_wvalid | input | 1 | Register write data valid |
| s_wready | output | 1 | Register write data ready |
| s_bresp | output | 2 | Register write response (always OKAY) |
| s_bvalid | output | 1 | Register write response valid |
| s_bready | input | 1 | Register write response ready |
| s_araddr | input | 8 | Register read address |
| s_arvalid | input | 1 | Register read address valid |
| s_arready | output | 1 | Register read address ready |
| s_rdata | output | 32 | Register read data |
| s_rresp | output | 2 | Register read response (always OKAY) |
| s_rvalid | output | 1 | Register read data valid |
| s_rready | input | 1 | Register read data ready |
| m_araddr | output | 32 | Memory read burst address |
| m_arlen | output | 8 | Memory read burst length minus one |
| m_arsize | output | 3 | Memory read beat size |
| m_arburst | output | 2 | Memory read burst type |
| m_arvalid | output | 1 | Memory read address valid |
| m_arready | input | 1 | Memory read address ready |
| m_rdata | input | 128 | Memory read data |
| m_rlast | input | 1 | Last read beat of burst |
| m_rvalid | input | 1 | Memory read data valid |
| m_rready | output | 1 | Memory read data ready |
| m_awaddr | output | 32 | Memory write burst address |
| m_awlen | output | 8 | Memory write burst length minus one |
| m_awsize | output | 3 | Memory write beat size |
| m_awburst | output | 2 | Memory write burst type |
| m_awvalid | output | 1 | Memory write address valid |
| m_awready | input | 1 | Memory write address ready |
| m_wdata | output | 128 | Memory write data |
| m_wstrb | output | 16 | Memory write byte strobes (all set) |
| m_wlast | output | 1 | Last write beat of burst |
| m_wvalid | output | 1 | Memory write data valid |
| m_wready | input | 1 | Memory write data ready |
| m_bvalid | input | 1 | Memory write response valid |
| m_bready | output | 1 | Memory write response ready |

## Verification
The bench goes after the burst split at the boundary. A 32-beat copy under a 64-beat maximum must produce a single AxLEN of 0x1F, and a 20-beat copy under an 8-beat maximum must produce a 4-beat tail. An off-by-one in the split would show up as an extra burst, a wrong tail length or a missing last beat. Random ready and valid stalls on every memory channel, together with a per-beat sequence number in the read data, expose a design that drops, repeats or reorders beats when the far side pauses mid-burst. The keyhole runs would catch an address that still advances, or a burst type left at INCR. A length write issued mid-copy and a zero-length write catch an engine that restarts on its own trigger, or one that hangs waiting for data that never comes.

// File: rtl/mcopy_pkg.sv
package mcopy_pkg;
    localparam int CSR_W = 32;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;
    localparam logic [7:0] OFS_SRC  = 8'h18;
    localparam logic [7:0] OFS_DST  = 8'h20;
    localparam logic [7:0] OFS_LEN  = 8'h28;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01
    } burst_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_ADDR,
        RD_DATA
    } rd_st_e;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_ADDR,
        WR_DATA,
        WR_RESP
    } wr_st_e;
endpackage

// File: rtl/mcopy_fifo.sv
module mcopy_fifo #(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [DATA_W-1:0]            data_i,
    input  logic                         pop_i,
    output logic [DATA_W-1:0]            data_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o,
    output logic                         empty_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic full;

    assign full    = (q.cnt == CNT_W'(DEPTH));
    assign empty_o = (q.cnt == '0);
    assign count_o = q.cnt;
    assign data_o  = mem_q[q.rp];

    always_comb begin
        d = q;
        if (push_i) d.wp = q.wp + 1'b1;
        if (pop_i)  d.rp = q.rp + 1'b1;
        case ({push_i, pop_i})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[q.wp] <= data_i;
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (!full || pop_i));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/mcopy_csr.sv
module mcopy_csr
    import mcopy_pkg::*;
#(
    parameter int BYTE_SH = 4,
    parameter int MB_W    = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 s_awaddr,
    input  logic                       s_awvalid,
    output logic                       s_awready,
    input  logic [CSR_W-1:0]           s_wdata,
    input  logic                       s_wvalid,
    output logic                       s_wready,
    output logic                       s_bvalid,
    input  logic                       s_bready,
    input  logic [7:0]                 s_araddr,
    input  logic                       s_arvalid,
    output logic                       s_arready,
    output logic [CSR_W-1:0]           s_rdata,
    output logic                       s_rvalid,
    input  logic                       s_rready,
    input  logic                       fin_i,
    output logic                       go_o,
    output logic [CSR_W-BYTE_SH-1:0]   beats_o,
    output logic [CSR_W-1:0]           src_o,
    output logic [CSR_W-1:0]           dst_o,
    output logic                       kh_rd_o,
    output logic                       kh_wr_o,
    output logic [MB_W-1:0]            mb_m1_o
);
    localparam int BEAT_W = CSR_W - BYTE_SH;

    typedef struct packed {
        logic              kr;
        logic              kw;
        logic [MB_W-1:0]   mb;
        logic [CSR_W-1:0]  src;
        logic [CSR_W-1:0]  dst;
        logic [CSR_W-1:0]  len;
        logic              busy;
        logic              done;
        logic              bvld;
        logic              rvld;
        logic [CSR_W-1:0]  rdata;
    } csr_t;

    csr_t q, d;
    logic wr_acc, ar_acc;
    logic [CSR_W-1:0] rd_mux;

    assign wr_acc    = s_awvalid && s_wvalid && !q.bvld;
    assign ar_acc    = s_arvalid && !q.rvld;
    assign s_awready = wr_acc;
    assign s_wready  = wr_acc;
    assign s_bvalid  = q.bvld;
    assign s_arready = !q.rvld;
    assign s_rvalid  = q.rvld;
    assign s_rdata   = q.rdata;
    assign beats_o   = s_wdata[CSR_W-1:BYTE_SH];
    assign src_o     = q.src;
    assign dst_o     = q.dst;
    assign kh_rd_o   = q.kr;
    assign kh_wr_o   = q.kw;
    assign mb_m1_o   = q.mb;

    always_comb begin
        rd_mux = '0;
        case (s_araddr)
            OFS_CTRL: begin
                rd_mux[4]         = q.kr;
                rd_mux[5]         = q.kw;
                rd_mux[8 +: MB_W] = q.mb;
            end
            OFS_STAT: begin
                rd_mux[0] = q.done;
                rd_mux[1] = !q.busy;
            end
            OFS_SRC: rd_mux = q.src;
            OFS_DST: rd_mux = q.dst;
            OFS_LEN: rd_mux = q.len;
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        d    = q;
        go_o = 1'b0;
        if (q.bvld && s_bready) d.bvld = 1'b0;
        if (wr_acc) begin
            d.bvld = 1'b1;
            case (s_awaddr)
                OFS_CTRL: if (!q.busy) begin
                    d.kr = s_wdata[4];
                    d.kw = s_wdata[5];
                    d.mb = s_wdata[8 +: MB_W];
                end
                OFS_STAT: if (s_wdata[0]) d.done = 1'b0;
                OFS_SRC:  if (!q.busy) d.src = s_wdata;
                OFS_DST:  if (!q.busy) d.dst = s_wdata;
                OFS_LEN:  if (!q.busy) begin
                    d.len = s_wdata;
                    if (s_wdata[CSR_W-1:BYTE_SH] == BEAT_W'(0)) begin
                        d.done = 1'b1;
                    end else begin
                        d.busy = 1'b1;
                        d.done = 1'b0;
                        go_o   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (fin_i) begin
            d.busy = 1'b0;
            d.done = 1'b1;
        end
        if (q.rvld && s_rready) d.rvld = 1'b0;
        if (ar_acc) begin
            d.rvld  = 1'b1;
            d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.mb   <= '1;
        end else begin
            q <= d;
        end
    end

    // R11
    fin_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i |-> q.busy);
endmodule

// File: rtl/mcopy_rd.sv
module mcopy_rd
    import mcopy_pkg::*;
#(
    parameter int BYTE_SH = 4,
    parameter int MB_W    = 6,
    parameter int DEPTH   = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go_i,
    input  logic [CSR_W-BYTE_SH-1:0]     beats_i,
    input  logic [CSR_W-1:0]             src_i,
    input  logic                         kh_i,
    input  logic [MB_W-1:0]              mb_m1_i,
    input  logic [$clog2(DEPTH+1)-1:0]   fifo_cnt_i,
    output logic [CSR_W-1:0]             araddr_o,
    output logic [7:0]                   arlen_o,
    output logic [1:0]                   arburst_o,
    output logic                         arvalid_o,
    input  logic                         arready_i,
    input  logic                         rvalid_i,
    input  logic                         rlast_i,
    output logic                         rready_o,
    output logic                         push_o
);
    localparam int BEAT_W = CSR_W - BYTE_SH;

    typedef struct packed {
        rd_st_e            st;
        logic [BEAT_W-1:0] left;
        logic [CSR_W-1:0]  addr;
        logic              kh;
        logic [MB_W-1:0]   mb;
        logic [7:0]        len;
    } rd_t;

    rd_t q, d;
    logic [BEAT_W-1:0] cap, nb, room;

    assign cap  = BEAT_W'(q.mb) + 1'b1;
    assign nb   = (q.left > cap) ? cap : q.left;
    assign room = BEAT_W'(DEPTH) - BEAT_W'(fifo_cnt_i);

    assign araddr_o  = q.addr;
    assign arlen_o   = q.len;
    assign arburst_o = q.kh ? BURST_FIXED : BURST_INCR;
    assign arvalid_o = (q.st == RD_ADDR);
    assign rready_o  = (q.st == RD_DATA);
    assign push_o    = (q.st == RD_DATA) && rvalid_i;

    always_comb begin
        d = q;
        case (q.st)
            RD_IDLE: begin
                if (go_i) begin
                    d.left = beats_i;
                    d.addr = src_i;
                    d.kh   = kh_i;
                    d.mb   = mb_m1_i;
                end else if (q.left != '0 && room >= nb) begin
                    d.st  = RD_ADDR;
                    d.len = 8'(nb - 1'b1);
                end
            end
            RD_ADDR: begin
                if (arready_i) begin
                    d.st   = RD_DATA;
                    d.left = q.left - nb;
                    if (!q.kh) d.addr = q.addr + (CSR_W'(nb) << BYTE_SH);
                end
            end
            RD_DATA: begin
                if (rvalid_i && rlast_i) d.st = RD_IDLE;
            end
            default: d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid_o && !arready_i) |=> (arvalid_o && $stable(araddr_o) && $stable(arlen_o)));

    // R8
    rd_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid_o && arready_i) |-> (BEAT_W'(arlen_o) < room));
endmodule

// File: rtl/mcopy_wr.sv
module mcopy_wr
    import mcopy_pkg::*;
#(
    parameter int BYTE_SH = 4,
    parameter int MB_W    = 6,
    parameter int DEPTH   = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go_i,
    input  logic [CSR_W-BYTE_SH-1:0]     beats_i,
    input  logic [CSR_W-1:0]             dst_i,
    input  logic                         kh_i,
    input  logic [MB_W-1:0]              mb_m1_i,
    input  logic [$clog2(DEPTH+1)-1:0]   fifo_cnt_i,
    input  logic                         fifo_empty_i,
    output logic [CSR_W-1:0]             awaddr_o,
    output logic [7:0]                   awlen_o,
    output logic [1:0]                   awburst_o,
    output logic                         awvalid_o,
    input  logic                         awready_i,
    output logic                         wlast_o,
    output logic                         wvalid_o,
    input  logic                         wready_i,
    input  logic                         bvalid_i,
    output logic                         bready_o,
    output logic                         pop_o,
    output logic                         fin_o
);
    localparam int BEAT_W = CSR_W - BYTE_SH;

    typedef struct packed {
        wr_st_e            st;
        logic [BEAT_W-1:0] left;
        logic [CSR_W-1:0]  addr;
        logic              kh;
        logic [MB_W-1:0]   mb;
        logic [7:0]        len;
        logic [7:0]        beat;
    } wr_t;

    wr_t q, d;
    logic [BEAT_W-1:0] cap, nb;

    assign cap = BEAT_W'(q.mb) + 1'b1;
    assign nb  = (q.left > cap) ? cap : q.left;

    assign awaddr_o  = q.addr;
    assign awlen_o   = q.len;
    assign awburst_o = q.kh ? BURST_FIXED : BURST_INCR;
    assign awvalid_o = (q.st == WR_ADDR);
    assign wvalid_o  = (q.st == WR_DATA) && !fifo_empty_i;
    assign wlast_o   = (q.beat == q.len);
    assign bready_o  = (q.st == WR_RESP);
    assign pop_o     = wvalid_o && wready_i;
    assign fin_o     = (q.st == WR_RESP) && bvalid_i && (q.left == '0);

    always_comb begin
        d = q;
        case (q.st)
            WR_IDLE: begin
                if (go_i) begin
                    d.left = beats_i;
                    d.addr = dst_i;
                    d.kh   = kh_i;
                    d.mb   = mb_m1_i;
                end else if (q.left != '0 && BEAT_W'(fifo_cnt_i) >= nb) begin
                    d.st   = WR_ADDR;
                    d.len  = 8'(nb - 1'b1);
                    d.beat = '0;
                end
            end
            WR_ADDR: begin
                if (awready_i) begin
                    d.st   = WR_DATA;
                    d.left = q.left - nb;
                    if (!q.kh) d.addr = q.addr + (CSR_W'(nb) << BYTE_SH);
                end
            end
            WR_DATA: begin
                if (pop_o) begin
                    d.beat = q.beat + 1'b1;
                    if (wlast_o) d.st = WR_RESP;
                end
            end
            WR_RESP: begin
                if (bvalid_i) d.st = WR_IDLE;
            end
            default: d.st = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wvalid_o && !wready_i) |=> (wvalid_o && $stable(wlast_o)));

    // R8
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid_o && !awready_i) |=> (awvalid_o && $stable(awaddr_o) && $stable(awlen_o)));

    // R8
    w_data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == WR_DATA) |-> !fifo_empty_i);
endmodule

// File: rtl/mcopy_engine.sv
module mcopy_engine
    import mcopy_pkg::*;
#(
    parameter int DATA_W     = 128,
    parameter int FIFO_DEPTH = 64,
    parameter int MB_W       = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           s_awaddr,
    input  logic                 s_awvalid,
    output logic                 s_awready,
    input  logic [31:0]          s_wdata,
    input  logic                 s_wvalid,
    output logic                 s_wready,
    output logic [1:0]           s_bresp,
    output logic                 s_bvalid,
    input  logic                 s_bready,
    input  logic [7:0]           s_araddr,
    input  logic                 s_arvalid,
    output logic                 s_arready,
    output logic [31:0]          s_rdata,
    output logic [1:0]           s_rresp,
    output logic                 s_rvalid,
    input  logic                 s_rready,
    output logic [31:0]          m_araddr,
    output logic [7:0]           m_arlen,
    output logic [2:0]           m_arsize,
    output logic [1:0]           m_arburst,
    output logic                 m_arvalid,
    input  logic                 m_arready,
    input  logic [DATA_W-1:0]    m_rdata,
    input  logic                 m_rlast,
    input  logic                 m_rvalid,
    output logic                 m_rready,
    output logic [31:0]          m_awaddr,
    output logic [7:0]           m_awlen,
    output logic [2:0]           m_awsize,
    output logic [1:0]           m_awburst,
    output logic                 m_awvalid,
    input  logic                 m_awready,
    output logic [DATA_W-1:0]    m_wdata,
    output logic [DATA_W/8-1:0]  m_wstrb,
    output logic                 m_wlast,
    output logic                 m_wvalid,
    input  logic                 m_wready,
    input  logic                 m_bvalid,
    output logic                 m_bready
);
    localparam int BYTE_SH = $clog2(DATA_W/8);
    localparam int BEAT_W  = CSR_W - BYTE_SH;
    localparam int CNT_W   = $clog2(FIFO_DEPTH+1);

    logic              go, fin, kh_rd, kh_wr, push, pop, f_empty;
    logic [BEAT_W-1:0] beats;
    logic [CSR_W-1:0]  src, dst;
    logic [MB_W-1:0]   mb_m1;
    logic [CNT_W-1:0]  f_cnt;

    assign s_bresp  = 2'b00;
    assign s_rresp  = 2'b00;
    assign m_arsize = 3'(BYTE_SH);
    assign m_awsize = 3'(BYTE_SH);
    assign m_wstrb  = '1;

    mcopy_csr #(.BYTE_SH(BYTE_SH), .MB_W(MB_W)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .fin_i(fin), .go_o(go), .beats_o(beats), .src_o(src), .dst_o(dst),
        .kh_rd_o(kh_rd), .kh_wr_o(kh_wr), .mb_m1_o(mb_m1)
    );

    mcopy_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .data_i(m_rdata), .pop_i(pop),
        .data_o(m_wdata), .count_o(f_cnt), .empty_o(f_empty)
    );

    mcopy_rd #(.BYTE_SH(BYTE_SH), .MB_W(MB_W), .DEPTH(FIFO_DEPTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .go_i(go), .beats_i(beats), .src_i(src),
        .kh_i(kh_rd), .mb_m1_i(mb_m1), .fifo_cnt_i(f_cnt),
        .araddr_o(m_araddr), .arlen_o(m_arlen), .arburst_o(m_arburst),
        .arvalid_o(m_arvalid), .arready_i(m_arready),
        .rvalid_i(m_rvalid), .rlast_i(m_rlast), .rready_o(m_rready),
        .push_o(push)
    );

    mcopy_wr #(.BYTE_SH(BYTE_SH), .MB_W(MB_W), .DEPTH(FIFO_DEPTH)) u_wr (
        .clk(clk), .rst_n(rst_n), .go_i(go), .beats_i(beats), .dst_i(dst),
        .kh_i(kh_wr), .mb_m1_i(mb_m1), .fifo_cnt_i(f_cnt), .fifo_empty_i(f_empty),
        .awaddr_o(m_awaddr), .awlen_o(m_awlen), .awburst_o(m_awburst),
        .awvalid_o(m_awvalid), .awready_i(m_awready),
        .wlast_o(m_wlast), .wvalid_o(m_wvalid), .wready_i(m_wready),
        .bvalid_i(m_bvalid), .bready_o(m_bready), .pop_o(pop), .fin_o(fin)
    );

    // R4
    arlen_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> (m_arlen <= 8'(mb_m1)));

    // R4
    awlen_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (m_awlen <= 8'(mb_m1)));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid || m_awvalid || m_wvalid) |-> !go);
endmodule

// File: tb/mcopy_engine_tb.sv
module mcopy_engine_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [7:0]   s_awaddr = '0, s_araddr = '0;
    logic         s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
    logic [31:0]  s_wdata = '0;
    logic         s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]   s_bresp, s_rresp;
    logic [31:0]  s_rdata;
    logic [31:0]  m_araddr, m_awaddr;
    logic [7:0]   m_arlen, m_awlen;
    logic [2:0]   m_arsize, m_awsize;
    logic [1:0]   m_arburst, m_awburst;
    logic         m_arvalid, m_rready, m_awvalid, m_wlast, m_wvalid, m_bready;
    logic         m_arready = 1'b0, m_rvalid = 1'b0, m_rlast = 1'b0;
    logic         m_awready = 1'b0, m_wready = 1'b0, m_bvalid = 1'b0;
    logic [127:0] m_rdata = '0, m_wdata;
    logic [15:0]  m_wstrb;

    mcopy_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(1'b1),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(1'b1),
        .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
        .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rlast(m_rlast), .m_rvalid(m_rvalid), .m_rready(m_rready),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
        .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bvalid(m_bvalid), .m_bready(m_bready)
    );

    int total = 0;
    int bad   = 0;
    bit stress = 1'b0;
    bit w_block = 1'b0;

    // reference model state
    logic [41:0]  exp_ar[$];
    logic [41:0]  exp_aw[$];
    logic [128:0] exp_w[$];
    logic [32:0]  rq[$];
    int           rd_seq = 0;
    int           bpend = 0;
    int           n_ar = 0, n_aw = 0, n_w = 0;
    logic [7:0]   last_arlen = '0;

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] beat_data(input int seq, input logic [31:0] a);
        return {seq[31:0], a, ~seq[31:0], 32'h5A5A0F0F};
    endfunction

    // memory-side slave and per-clock comparison
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n) begin
                if (m_arvalid && m_arready) begin
                    n_ar++;
                    last_arlen = m_arlen;
                    if (exp_ar.size() == 0) chk("R9", "unexpected AR", {m_araddr, m_arlen, m_arburst}, '0);
                    else chk("R4", "AR addr/len/burst", {m_araddr, m_arlen, m_arburst}, exp_ar.pop_front());
                    chk("R5", "ARSIZE", m_arsize, 3'd4);
                    for (int i = 0; i <= m_arlen; i++)
                        rq.push_back({(i == m_arlen), (m_arburst == 2'b00) ? m_araddr : m_araddr + 32'(16*i)});
                end
                if (m_rvalid && m_rready) begin
                    void'(rq.pop_front());
                    rd_seq++;
                end
                if (m_awvalid && m_awready) begin
                    n_aw++;
                    if (exp_aw.size() == 0) chk("R9", "unexpected AW", {m_awaddr, m_awlen, m_awburst}, '0);
                    else chk("R7", "AW addr/len/burst", {m_awaddr, m_awlen, m_awburst}, exp_aw.pop_front());
                    chk("R5", "AWSIZE", m_awsize, 3'd4);
                end
                if (m_wvalid && m_wready) begin
                    n_w++;
                    if (exp_w.size() == 0) chk("R8", "unexpected W beat", m_wdata, '0);
                    else begin
                        logic [128:0] e;
                        e = exp_w.pop_front();
                        chk("R8", "W data", m_wdata, e[127:0]);
                        chk("R4", "WLAST", {127'd0, m_wlast}, {127'd0, e[128]});
                    end
                    if (m_wlast) bpend++;
                end
                if (m_bvalid && m_bready) bpend--;
            end
            @(negedge clk);
            m_arready = !(stress && $urandom_range(0, 2) == 0);
            m_awready = !(stress && $urandom_range(0, 2) == 0);
            m_wready  = !w_block && !(stress && $urandom_range(0, 2) == 0);
            if (!m_rvalid || m_rready) begin
                m_rvalid = (rq.size() > 0) && !(stress && $urandom_range(0, 2) == 0);
                if (rq.size() > 0) begin
                    m_rlast = rq[0][32];
                    m_rdata = beat_data(rd_seq, rq[0][31:0]);
                end
            end
            if (!m_bvalid || m_bready)
                m_bvalid = (bpend > 0) && !(stress && $urandom_range(0, 2) == 0);
        end
    end

    task automatic csr_wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        s_awaddr = a; s_wdata = v; s_awvalid = 1'b1; s_wvalid = 1'b1;
        do @(posedge clk); while (!s_awready);
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        do @(posedge clk); while (!s_bvalid);
    endtask

    task automatic csr_rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1'b1;
        do @(posedge clk); while (!s_arready);
        @(negedge clk);
        s_arvalid = 1'b0;
        do @(posedge clk); while (!s_rvalid);
        v = s_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        for (int n = 0; n < 4000; n++) begin
            csr_rd(8'h04, st);
            if (st[1]) return;
        end
        chk("R11", "idle never returned", 0, 1);
    endtask

    task automatic build_exp(input logic [31:0] src, input logic [31:0] dst,
                             input logic [31:0] len, input logic [31:0] ctrl);
        int left, maxb, k, nb;
        logic [31:0] a, b;
        left = int'(len >> 4);
        maxb = int'((ctrl >> 8) & 32'h3F) + 1;
        a = src; b = dst; k = 0;
        while (left > 0) begin
            nb = (left > maxb) ? maxb : left;
            exp_ar.push_back({a, 8'(nb - 1), ctrl[4] ? 2'b00 : 2'b01});
            exp_aw.push_back({b, 8'(nb - 1), ctrl[5] ? 2'b00 : 2'b01});
            for (int i = 0; i < nb; i++) begin
                exp_w.push_back({(i == nb - 1),
                    beat_data(k, ctrl[4] ? src : src + 32'(16*k))});
                k++;
            end
            if (!ctrl[4]) a = a + 32'(16*nb);
            if (!ctrl[5]) b = b + 32'(16*nb);
            left -= nb;
        end
    endtask

    task automatic run_copy(input string req, input logic [31:0] src, input logic [31:0] dst,
                            input logic [31:0] len, input logic [31:0] ctrl);
        logic [31:0] st;
        csr_wr(8'h00, ctrl);
        csr_wr(8'h18, src);
        csr_wr(8'h20, dst);
        build_exp(src, dst, len, ctrl);
        rd_seq = 0;
        n_w = 0;
        csr_wr(8'h28, len);
        wait_idle();
        repeat (5) @(posedge clk);
        chk(req, "leftover expected bursts/beats", 128'(exp_ar.size() + exp_aw.size() + exp_w.size()), 0);
        chk("R3", "beats written", 128'(n_w), 128'(len >> 4));
        csr_rd(8'h04, st);
        chk("R11", "status after copy", st, 32'h3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "AR/AW/W valid at reset", {m_arvalid, m_awvalid, m_wvalid}, 3'b000);
        csr_rd(8'h04, v); chk("R1", "status at reset", v, 32'h2);
        csr_rd(8'h00, v); chk("R1", "control at reset", v, 32'h3F00);

        // R2 register readback
        csr_wr(8'h18, 32'h1234_5670);
        csr_wr(8'h20, 32'hABCD_0010);
        csr_wr(8'h00, 32'hFFFF_FFFF);
        csr_rd(8'h18, v); chk("R2", "source readback", v, 32'h1234_5670);
        csr_rd(8'h20, v); chk("R2", "destination readback", v, 32'hABCD_0010);
        csr_rd(8'h00, v); chk("R2", "control readback", v, 32'h3F30);

        // R4 one 32-beat burst for 512 bytes with max 64
        n_ar = 0;
        run_copy("R3", 32'hC000_0000, 32'hC000_1000, 32'd512, 32'h3F00);
        chk("R4", "512B burst count", 128'(n_ar), 1);
        chk("R4", "512B AxLEN", last_arlen, 8'h1F);
        csr_rd(8'h28, v); chk("R2", "length readback", v, 32'd512);

        // R4 R5 split at max 8 with a 4-beat tail, under stalls
        stress = 1'b1;
        n_ar = 0;
        run_copy("R5", 32'h0000_2000, 32'h0000_8000, 32'd320, 32'h0700);
        chk("R4", "split burst count", 128'(n_ar), 3);
        chk("R4", "tail AxLEN", last_arlen, 8'h03);

        // R6 keyhole read
        run_copy("R6", 32'h4300_0000, 32'hC000_1000, 32'd256, 32'h0710);

        // R7 keyhole write
        run_copy("R7", 32'hC000_0000, 32'h4300_0040, 32'd160, 32'h0320);

        // R8 long stalled write side then release
        w_block = 1'b1;
        csr_wr(8'h00, 32'h3F00);
        csr_wr(8'h18, 32'h0001_0000);
        csr_wr(8'h20, 32'h0002_0000);
        build_exp(32'h0001_0000, 32'h0002_0000, 32'd2048, 32'h3F00);
        rd_seq = 0; n_w = 0;
        csr_wr(8'h28, 32'd2048);
        repeat (300) @(posedge clk);
        w_block = 1'b0;
        wait_idle();
        repeat (5) @(posedge clk);
        chk("R8", "leftover after blocked writes", 128'(exp_ar.size() + exp_aw.size() + exp_w.size()), 0);
        chk("R8", "beats after blocked writes", 128'(n_w), 128);

        // R9 writes while busy are ignored
        csr_wr(8'h00, 32'h0F00);
        csr_wr(8'h18, 32'h0005_0000);
        csr_wr(8'h20, 32'h0006_0000);
        build_exp(32'h0005_0000, 32'h0006_0000, 32'd1024, 32'h0F00);
        rd_seq = 0; n_w = 0;
        csr_wr(8'h28, 32'd1024);
        csr_rd(8'h04, v); chk("R11", "idle low while busy", {31'd0, v[1]}, 0);
        csr_wr(8'h28, 32'd64);
        csr_wr(8'h18, 32'h0BAD_0000);
        csr_wr(8'h00, 32'h0030);
        wait_idle();
        repeat (40) @(posedge clk);
        chk("R9", "extra bursts after busy write", 128'(exp_ar.size() + exp_aw.size() + exp_w.size()), 0);
        chk("R9", "beats with busy writes", 128'(n_w), 64);
        csr_rd(8'h28, v); chk("R9", "length kept", v, 32'd1024);
        csr_rd(8'h18, v); chk("R9", "source kept", v, 32'h0005_0000);
        csr_rd(8'h00, v); chk("R9", "control kept", v, 32'h0F00);

        // R11 write-one-to-clear
        csr_wr(8'h04, 32'h0);
        csr_rd(8'h04, v); chk("R11", "done after writing 0", v, 32'h3);
        csr_wr(8'h04, 32'h1);
        csr_rd(8'h04, v); chk("R11", "done after writing 1", v, 32'h2);

        // R10 zero length
        n_ar = 0; n_aw = 0;
        csr_wr(8'h28, 32'd8);
        csr_rd(8'h04, v); chk("R10", "status after zero length", v, 32'h3);
        repeat (20) @(posedge clk);
        chk("R10", "no bursts for zero length", 128'(n_ar + n_aw), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule